// File: doc/BRIEF.md
# Level-Sensitive Interrupt Distributor Core

This block gathers a parameterised set of level-sensitive interrupt lines and delivers them to a small cluster of CPUs through a 32-bit memory-mapped register port. Each line has an enable bit and a CPU routing mask. Enable bits change only through write-one set and clear strobe registers. Each CPU has one interrupt output. That output stays high while any line routed to that CPU is both asserted and enabled.

A CPU services its interrupt by reading its claim register. The read returns an event word that holds a type and a line number. The line returned is the lowest-numbered line that is asserted, enabled and routed to the reader. The same read also clears that line's enable bit, so software reads the claim register again and again until it returns the empty type, then re-enables each line once it has been serviced. The CPU index of an access comes in on a sideband input for the local window. A set of per-CPU alias windows gives access to the claim register of a specific CPU whatever the sideband carries.

Top module: `intc_core`

## Requirements
- R1: A read of address 0x0000 returns the IDENT parameter. A read of 0x0004 returns the number of implemented lines in bits 15:0 and zero in bits 31:16.
- R2: After reset every enable bit is 0, every routing mask reads 1 (CPU 0 only) and every `cpu_irq` bit is low.
- R3: Every read accepted in cycle N gives `rsp_valid` high with `rsp_rdata` in cycle N+1. A claim word carries the type in bits 19:16 (0 = nothing eligible, 1 = a hardware line) and the line number in bits 11:0, with all other bits zero. An empty claim reads as all zeros.
- R4: A write to 0x4180+4*g sets the enable of line 32*g+b for every bit b written as 1. A write to 0x4100+4*g clears those enables. Bits written as 0 change nothing. Reading either address returns the 32 enable bits of group g.
- R5: A claim read that returns a line clears that line's enable bit at the same clock edge, so a later claim does not return the line again until software re-enables it.
- R6: When several lines are eligible, the claim returns the lowest-numbered line that is asserted, enabled and routed to the claiming CPU.
- R7: Address 0x3000+4*i holds the routing mask of line i in its low NUM_CPUS bits, and bit n allows delivery to CPU n. Higher written bits are dropped and read back as 0.
- R8: In the local window, 0x2000 returns the sideband CPU index and 0x2004 is that CPU's claim register. Alias window c at 0x5000+(c<<7) returns c at offset 0 and claims for CPU c at offset 4. Alias windows with c >= NUM_CPUS read as zero.
- R9: `cpu_irq[c]` is high in the same cycle as any line that is asserted, enabled and routed to CPU c.
- R10: Claims follow the live line level. A line that drops before the claim is not returned, and its enable bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt inputs |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | Index of the CPU making the access |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
Read data, claim words and the effect of a claim on an enable bit all appear one clock edge after the request cycle. `cpu_irq` follows the lines and the enable state without a register. So `cpu_irq` changes in the cycle a line moves, and in the cycle after a strobe or a claim. The bench drives each request on a falling edge and updates its reference model for the rising edge that follows. At the next falling edge it compares `rsp_valid`, `rsp_rdata` and every `cpu_irq` bit against the model. Every check therefore samples the cycle in which its result is due.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam logic [3:0] EVT_NONE = 4'd0;
  localparam logic [3:0] EVT_LINE = 4'd1;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_IDENT,
    RD_CONFIG,
    RD_CPUID,
    RD_ACK,
    RD_AFFIN,
    RD_GROUP
  } rd_sel_e;

  // Claim word: type in 19:16, line number in 11:0.
  function automatic logic [31:0] pack_claim(input logic hit, input logic [11:0] num);
    pack_claim = hit ? {12'd0, EVT_LINE, 4'd0, num} : 32'd0;
  endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int NUM_CPUS   = 4,
  parameter int NUM_GROUPS = 2,
  parameter int LINE_W     = 6,
  parameter int CPU_W      = 2,
  parameter int GRP_W      = 1
) (
  input  logic [15:0]       addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output rd_sel_e           sel,
  output logic [LINE_W-1:0] line_idx,
  output logic [GRP_W-1:0]  grp_idx,
  output logic              grp_set,
  output logic [CPU_W-1:0]  tgt_cpu
);

  logic [3:0] page;
  logic [9:0] aff_raw;
  logic [4:0] grp_raw;
  logic [4:0] alias_raw;

  assign page      = addr[15:12];
  assign aff_raw   = addr[11:2];
  assign grp_raw   = addr[6:2];
  assign alias_raw = addr[11:7];

  function automatic logic word_ok(input logic [15:0] a);
    return a[1:0] == 2'b00;
  endfunction

  always_comb begin
    sel      = RD_ZERO;
    tgt_cpu  = req_cpu;
    grp_set  = addr[7];
    line_idx = aff_raw[LINE_W-1:0];
    grp_idx  = grp_raw[GRP_W-1:0];
    if (addr == 16'h0000) begin
      sel = RD_IDENT;
    end else if (addr == 16'h0004) begin
      sel = RD_CONFIG;
    end else if (page == 4'h2) begin
      if (addr[11:0] == 12'h000)      sel = RD_CPUID;
      else if (addr[11:0] == 12'h004) sel = RD_ACK;
    end else if (page == 4'h3) begin
      if (word_ok(addr) && int'(aff_raw) < NUM_LINES) sel = RD_AFFIN;
    end else if (addr[15:8] == 8'h41) begin
      if (word_ok(addr) && int'(grp_raw) < NUM_GROUPS) sel = RD_GROUP;
    end else if (page == 4'h5 && int'(alias_raw) < NUM_CPUS) begin
      tgt_cpu = alias_raw[CPU_W-1:0];
      if (addr[6:0] == 7'h00)      sel = RD_CPUID;
      else if (addr[6:0] == 7'h04) sel = RD_ACK;
    end
  end

endmodule

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
  parameter int NUM_LINES  = 64,
  parameter int NUM_GROUPS = 2,
  parameter int LINE_W     = 6,
  parameter int GRP_W      = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [GRP_W-1:0]     grp_idx,
  input  logic [31:0]          wdata,
  input  logic                 claim_clr,
  input  logic [LINE_W-1:0]    claim_idx,
  output logic [NUM_LINES-1:0] en_q,
  output logic [31:0]          grp_view
);

  localparam int PAD_W = NUM_GROUPS * 32;

  logic [NUM_LINES-1:0] set_mask;
  logic [NUM_LINES-1:0] clr_mask;
  logic [NUM_LINES-1:0] claim_mask;
  logic [PAD_W-1:0]     en_pad;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int GRP = i / 32;
    localparam int BIT = i % 32;
    assign set_mask[i]   = set_we && (int'(grp_idx) == GRP) && wdata[BIT];
    assign clr_mask[i]   = clr_we && (int'(grp_idx) == GRP) && wdata[BIT];
    assign claim_mask[i] = claim_clr && (int'(claim_idx) == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_mask) & ~clr_mask & ~claim_mask;
  end

  always_comb begin
    en_pad                = '0;
    en_pad[NUM_LINES-1:0] = en_q;
  end

  assign grp_view = en_pad[int'(grp_idx)*32 +: 32];

  // R4
  zero_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_clr && (wdata == 32'd0 || !(set_we || clr_we))) |=> $stable(en_q));

  // R5
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_clr |=> !en_q[$past(claim_idx)]);

endmodule

// File: rtl/intc_route_bank.sv
module intc_route_bank #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  parameter int LINE_W    = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [LINE_W-1:0]                  idx,
  input  logic [NUM_CPUS-1:0]                wdata,
  output logic [NUM_LINES-1:0][NUM_CPUS-1:0] route_q,
  output logic [NUM_CPUS-1:0]                route_view
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) route_q[i] <= NUM_CPUS'(1);
    end else if (we && int'(idx) < NUM_LINES) begin
      route_q[idx] <= wdata;
    end
  end

  assign route_view = (int'(idx) < NUM_LINES) ? route_q[idx] : '0;

  // R7
  route_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(idx) < NUM_LINES) |=> route_q[$past(idx)] == $past(wdata));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  parameter int LINE_W    = 6,
  parameter int CPU_W     = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_LINES-1:0]               lines,
  input  logic [NUM_LINES-1:0]               en,
  input  logic [NUM_LINES-1:0][NUM_CPUS-1:0] route,
  input  logic [CPU_W-1:0]                   sel_cpu,
  output logic [NUM_CPUS-1:0]                cpu_pending,
  output logic                               pick_valid,
  output logic [LINE_W-1:0]                  pick_idx
);

  logic [NUM_CPUS-1:0][NUM_LINES-1:0] route_col;
  logic [NUM_LINES-1:0]               cand;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
      assign route_col[c][i] = route[i][c];
    end
    assign cpu_pending[c] = |(lines & en & route_col[c]);
  end

  assign cand = (int'(sel_cpu) < NUM_CPUS) ? (lines & en & route_col[sel_cpu]) : '0;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_valid = 1'b1;
        pick_idx   = LINE_W'(i);
      end
    end
  end

  function automatic logic [NUM_LINES-1:0] below(input logic [LINE_W-1:0] k);
    return (NUM_LINES'(1) << k) - NUM_LINES'(1);
  endfunction

  // R6
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (cand[pick_idx] && ((cand & below(pick_idx)) == '0)));

  // R6
  pick_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> (cand == '0));

  // R9
  pending_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_cpu) < NUM_CPUS) |-> (cpu_pending[sel_cpu] == pick_valid));

endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int          NUM_LINES = 64,
  parameter int          NUM_CPUS  = 4,
  parameter logic [31:0] IDENT     = 32'h4943_0100,
  localparam int         CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [CPU_W-1:0]     req_cpu,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_CPUS-1:0]  cpu_irq
);

  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int NUM_GROUPS = (NUM_LINES + 31) / 32;
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  rd_sel_e                            sel;
  logic [LINE_W-1:0]                  line_idx;
  logic [GRP_W-1:0]                   grp_idx;
  logic                               grp_set;
  logic [CPU_W-1:0]                   tgt_cpu;
  logic [NUM_LINES-1:0]               en_q;
  logic [31:0]                        grp_view;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0] route_q;
  logic [NUM_CPUS-1:0]                route_view;
  logic                               pick_valid;
  logic [LINE_W-1:0]                  pick_idx;
  logic                               rd_go, wr_go;
  logic                               claim_fire;
  logic                               claim_rsp_q;
  logic [31:0]                        rd_word;

  assign rd_go      = req_valid && !req_write;
  assign wr_go      = req_valid && req_write;
  assign claim_fire = rd_go && (sel == RD_ACK) && pick_valid;

  intc_decode #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .NUM_GROUPS(NUM_GROUPS),
    .LINE_W(LINE_W), .CPU_W(CPU_W), .GRP_W(GRP_W)
  ) u_decode (
    .addr(req_addr), .req_cpu(req_cpu), .sel(sel), .line_idx(line_idx),
    .grp_idx(grp_idx), .grp_set(grp_set), .tgt_cpu(tgt_cpu)
  );

  intc_enable_bank #(
    .NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_GROUPS), .LINE_W(LINE_W), .GRP_W(GRP_W)
  ) u_enables (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_go && sel == RD_GROUP && grp_set),
    .clr_we(wr_go && sel == RD_GROUP && !grp_set),
    .grp_idx(grp_idx), .wdata(req_wdata),
    .claim_clr(claim_fire), .claim_idx(pick_idx),
    .en_q(en_q), .grp_view(grp_view)
  );

  intc_route_bank #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LINE_W(LINE_W)
  ) u_routes (
    .clk(clk), .rst_n(rst_n),
    .we(wr_go && sel == RD_AFFIN), .idx(line_idx),
    .wdata(req_wdata[NUM_CPUS-1:0]),
    .route_q(route_q), .route_view(route_view)
  );

  intc_arbiter #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LINE_W(LINE_W), .CPU_W(CPU_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .en(en_q), .route(route_q),
    .sel_cpu(tgt_cpu), .cpu_pending(cpu_irq),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  always_comb begin
    case (sel)
      RD_IDENT:  rd_word = IDENT;
      RD_CONFIG: rd_word = {16'd0, 16'(NUM_LINES)};
      RD_CPUID:  rd_word = 32'(tgt_cpu);
      RD_ACK:    rd_word = pack_claim(pick_valid, 12'(pick_idx));
      RD_AFFIN:  rd_word = 32'(route_view);
      RD_GROUP:  rd_word = grp_view;
      default:   rd_word = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= 32'd0;
      claim_rsp_q <= 1'b0;
    end else begin
      rsp_valid   <= rd_go;
      claim_rsp_q <= rd_go && (sel == RD_ACK);
      if (rd_go) rsp_rdata <= rd_word;
    end
  end

  // R3
  claim_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rsp_q |-> ((rsp_rdata == 32'd0) ||
                     (rsp_rdata[19:16] == EVT_LINE && rsp_rdata[31:20] == 12'd0 &&
                      rsp_rdata[15:12] == 4'd0 && int'(rsp_rdata[11:0]) < NUM_LINES)));

  // R3
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid) && !$past(req_write));

endmodule

// File: tb/intc_core_tb.sv
`timescale 1ns/1ps
module intc_core_tb;

  localparam int NL = 64;
  localparam int NC = 4;
  localparam int NG = (NL + 31) / 32;
  localparam logic [31:0] ID = 32'h4943_0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_cpu = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] cpu_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  bit            en_m [NL];
  logic [NC-1:0] aff_m [NL];

  always #2.5 clk = ~clk;

  intc_core #(.NUM_LINES(NL), .NUM_CPUS(NC), .IDENT(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int m_pick(input int c);
    if (c >= NC) return -1;
    for (int i = 0; i < NL; i++)
      if (lines[i] && en_m[i] && aff_m[i][c]) return i;
    return -1;
  endfunction

  function automatic logic [NC-1:0] m_pending();
    logic [NC-1:0] p = '0;
    for (int c = 0; c < NC; c++) p[c] = (m_pick(c) >= 0);
    return p;
  endfunction

  function automatic logic [31:0] m_group(input int g);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) if (g*32 + b < NL) v[b] = en_m[g*32 + b];
    return v;
  endfunction

  function automatic logic [31:0] m_claim(input int c, output int claim);
    claim = m_pick(c);
    if (claim < 0) return 32'd0;
    return 32'h0001_0000 | 32'(claim);
  endfunction

  function automatic logic [31:0] m_read(input int a, input int c, output int claim);
    claim = -1;
    if (a == 'h0000) return ID;
    if (a == 'h0004) return NL;
    if (a == 'h2000) return 32'(c);
    if (a == 'h2004) return m_claim(c, claim);
    if (a >= 'h3000 && a < 'h3000 + 4*NL && a % 4 == 0) return 32'(aff_m[(a - 'h3000) / 4]);
    if (a >= 'h4100 && a < 'h4100 + 4*NG && a % 4 == 0) return m_group((a - 'h4100) / 4);
    if (a >= 'h4180 && a < 'h4180 + 4*NG && a % 4 == 0) return m_group((a - 'h4180) / 4);
    if (a >= 'h5000 && a < 'h5000 + 128*NC) begin
      int cc = (a - 'h5000) / 128;
      int off = (a - 'h5000) % 128;
      if (off == 0) return 32'(cc);
      if (off == 4) return m_claim(cc, claim);
    end
    return 32'd0;
  endfunction

  task automatic m_write(input int a, input logic [31:0] d);
    if (a >= 'h3000 && a < 'h3000 + 4*NL && a % 4 == 0) aff_m[(a - 'h3000) / 4] = d[NC-1:0];
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < 32; b++) begin
        if (d[b] && g*32 + b < NL) begin
          if (a == 'h4180 + 4*g) en_m[g*32 + b] = 1'b1;
          if (a == 'h4100 + 4*g) en_m[g*32 + b] = 1'b0;
        end
      end
    end
  endtask

  // Called at a falling edge; result compared at the next falling edge.
  task automatic step(input bit v, input bit w, input int a, input logic [31:0] d,
                      input int c, input string tag);
    logic [31:0] exp_d = '0;
    int claim;
    req_valid = v; req_write = w; req_addr = 16'(a); req_wdata = d; req_cpu = 2'(c);
    if (v && !w) begin
      exp_d = m_read(a, c, claim);
      if (claim >= 0) en_m[claim] = 1'b0;
    end else if (v) begin
      m_write(a, d);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R3", "rsp_valid", 32'(rsp_valid), 32'(v && !w));
    if (v && !w) chk(tag, $sformatf("read %h", a), rsp_rdata, exp_d);
    chk("R9", "cpu_irq", 32'(cpu_irq), 32'(m_pending()));
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin en_m[i] = 1'b0; aff_m[i] = NC'(1); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lines[3] = 1'b1; lines[7] = 1'b1; lines[40] = 1'b1;
    @(negedge clk);
    chk("R2", "cpu_irq after reset", 32'(cpu_irq), 32'd0);
    step(1, 0, 'h0004, 0, 0, "R1");
    step(1, 0, 'h0000, 0, 0, "R1");
    step(1, 0, 'h3014, 0, 0, "R2");
    step(1, 0, 'h4180, 0, 0, "R2");
    step(1, 0, 'h2004, 0, 0, "R2");
    // Enable lines 3, 7, 40
    step(1, 1, 'h4180, 32'h0000_0088, 0, "R4");
    step(1, 1, 'h4184, 32'h0000_0100, 0, "R4");
    step(1, 0, 'h4180, 0, 0, "R4");
    step(1, 1, 'h4180, 32'd0, 0, "R4");
    step(1, 1, 'h4100, 32'd0, 0, "R4");
    step(1, 0, 'h4100, 0, 0, "R4");
    // Drain: 3, 7, 40, then empty
    for (int k = 0; k < 4; k++) step(1, 0, 'h2004, 0, 0, "R6");
    step(1, 0, 'h4180, 0, 0, "R5");
    step(1, 0, 'h4184, 0, 0, "R5");
    step(1, 0, 'h2004, 0, 0, "R5");
    // Re-enable, then clear 7 only
    step(1, 1, 'h4180, 32'h0000_0088, 0, "R4");
    step(1, 1, 'h4100, 32'h0000_0080, 0, "R4");
    step(1, 0, 'h4180, 0, 0, "R4");
    // Routing
    step(1, 1, 'h300C, 32'h0000_0004, 0, "R7");
    step(1, 0, 'h300C, 0, 0, "R7");
    step(1, 1, 'h300C, 32'hFFFF_FFF2, 0, "R7");
    step(1, 0, 'h300C, 0, 0, "R7");
    step(1, 0, 'h2004, 0, 0, "R7");
    step(1, 0, 'h5084, 0, 0, "R8");
    step(1, 0, 'h2000, 0, 3, "R8");
    step(1, 0, 'h5100, 0, 0, "R8");
    step(1, 0, 'h5200, 0, 0, "R8");
    // Level follow: line 12 drops before the claim
    step(1, 1, 'h4180, 32'h0000_1000, 0, "R10");
    lines[12] = 1'b1;
    step(0, 0, 0, 0, 0, "R9");
    lines[12] = 1'b0;
    step(0, 0, 0, 0, 0, "R9");
    step(1, 0, 'h2004, 0, 0, "R10");
    step(1, 0, 'h4180, 0, 0, "R10");
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int kind = $urandom_range(0, 9);
      int a;
      logic [31:0] d = $urandom();
      if (n % 8 == 0) begin
        lines = {$urandom(), $urandom()};
        lines = lines & {$urandom(), $urandom()};
      end
      case (kind)
        0: a = 'h0000;
        1: a = 'h2000 + 4 * $urandom_range(0, 1);
        2, 3: a = 'h2004;
        4: a = 'h3000 + 4 * $urandom_range(0, NL + 1);
        5: a = 'h4100 + 4 * $urandom_range(0, NG);
        6: a = 'h4180 + 4 * $urandom_range(0, NG);
        7, 8: a = 'h5000 + 128 * $urandom_range(0, NC) + 4 * $urandom_range(0, 1);
        default: a = 'h1234;
      endcase
      if (kind == 5 || kind == 6) d = d & $urandom();
      step($urandom_range(0, 4) != 0, $urandom_range(0, 2) == 0, a, d,
           $urandom_range(0, NC - 1), "R6");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #500000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule